// File: doc/BRIEF.md
# Indexed Event Counter Bank

This block is a bank of event counters that sit behind a small auxiliary register bus. The core supplies a vector of condition lines, one for each countable condition, and each counter adds one on every clock in which its chosen condition is high while the global enable is set. Software never sees all the counters at once. A shared index register picks one counter, and the configuration, count and snapshot registers then act on that counter.

A counter is stopped by giving it condition number zero, which never fires. Software reads a wide counter without tearing by issuing a snapshot command through the control register. The command copies the selected counter into a holding pair, which software reads at leisure. Two read-only build registers report the counter count, the width code and the condition count. A second index selects a condition whose eight-character ASCII name is returned in two words.

Top module: `pct_bank`

## Requirements
- R1: After reset all counters, condition selections, the snapshot, the counter index (0x256), the condition index (0x240) and the enable read as zero. Any read of an address not listed here returns zero.
- R2: A counter whose condition number n lies in 1..NUM_COND-1 adds one on every clock edge where the enable is set and cond_in[n-1] is 1. It wraps to zero after 2^W-1, where W = 32 + 16*SIZE_CODE (48 by default).
- R3: The condition register (0x254) stores and reads back the byte written for the selected counter. Condition 0, and any number of NUM_COND or above, never counts.
- R4: Bit 0 of the control register (0x255) is a global enable and reads back as written. While it is 0 no counter changes except through a write.
- R5: Writing the control register with bit 16 set zeroes every counter on that edge, ahead of any increment. Bits 16 and 17 always read as zero.
- R6: A write to 0x250 replaces bits 31:0 of the selected counter. A write to 0x251 replaces bits W-1:32. Both reads return those parts. A write on the same edge as an increment wins over it.
- R7: Writing the control register with bit 17 set copies the selected counter's value from before that edge into the snapshot. Bits 31:0 of the snapshot read at 0x252 and bits W-1:32 read at 0x253. The snapshot then stays unchanged while the counter keeps running.
- R8: The counter index holds 6 bits. When it is NUM_CNT or more, the per-counter registers read zero, writes to them change nothing, and a snapshot command stores zero.
- R9: 0xF5 reads {8'h00, NUM_CNT[7:0], 6'b0, SIZE_CODE[1:0], version 8'h01}, which is 0x00040101 by default. 0xF6 reads {NUM_COND[15:0], 8'h00, version 8'h01}, which is 0x00080001 by default.
- R10: For the condition selected at 0x240, 0x241 returns name characters 0..3 and 0x242 returns characters 4..7, with the lowest byte holding the first character. Condition 0 is named "never". Condition k is named "cnd" followed by two uppercase hex digits of k, with NUL padding. Conditions of NUM_COND or above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cond_in | input | NUM_COND-1 | Condition lines; bit k is condition k+1 |

## Verification
The bench presets a counter two below its wrap point and lets it roll over. A design that carries into a phantom bit, or drops the upper half, reads a non-zero value after the wrap. It writes a count register and issues a snapshot while the selected condition is high. A wrong priority shows up as an off-by-one count, and a snapshot that samples after the edge shows one more than the count before it.

The clear command is issued with the enable set, which exposes a clear that loses to the increment. An index beyond the bank is selected and then written, which catches aliasing onto a real counter. Out-of-range condition numbers are configured and held high, which catches a counter that advances when it should not.

// File: rtl/pct_pkg.sv
package pct_pkg;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;

   localparam logic [ADDR_W-1:0] A_CNT_LO   = 12'h250;
   localparam logic [ADDR_W-1:0] A_CNT_HI   = 12'h251;
   localparam logic [ADDR_W-1:0] A_SNP_LO   = 12'h252;
   localparam logic [ADDR_W-1:0] A_SNP_HI   = 12'h253;
   localparam logic [ADDR_W-1:0] A_CFG      = 12'h254;
   localparam logic [ADDR_W-1:0] A_CTRL     = 12'h255;
   localparam logic [ADDR_W-1:0] A_IDX      = 12'h256;
   localparam logic [ADDR_W-1:0] A_BLD_CNT  = 12'h0F5;
   localparam logic [ADDR_W-1:0] A_BLD_COND = 12'h0F6;
   localparam logic [ADDR_W-1:0] A_CIDX     = 12'h240;
   localparam logic [ADDR_W-1:0] A_NAME0    = 12'h241;
   localparam logic [ADDR_W-1:0] A_NAME1    = 12'h242;

   localparam int EN_BIT   = 0;
   localparam int CLR_BIT  = 16;
   localparam int SNAP_BIT = 17;

   function automatic logic [7:0] hex_char(input logic [3:0] n);
      return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
   endfunction

   // Eight ASCII bytes, first character in the lowest byte.
   function automatic logic [63:0] cond_name(input logic [7:0] j);
      if (j == 8'd0)
         return {8'h00, 8'h00, 8'h00, 8'h72, 8'h65, 8'h76, 8'h65, 8'h6E};
      return {8'h00, 8'h00, 8'h00, hex_char(j[3:0]), hex_char(j[7:4]),
              8'h64, 8'h6E, 8'h63};
   endfunction
endpackage

// File: rtl/pct_names.sv
module pct_names import pct_pkg::*; #(
   parameter int NUM_COND = 8
) (
   input  logic [7:0]  cidx,
   output logic [31:0] word_lo,
   output logic [31:0] word_hi
);
   localparam logic [8:0] NCOND9 = 9'(NUM_COND);
   logic [63:0] name;

   always_comb begin
      if ({1'b0, cidx} < NCOND9) name = cond_name(cidx);
      else                       name = '0;
   end

   assign word_lo = name[31:0];
   assign word_hi = name[63:32];
endmodule

// File: rtl/pct_counter.sv
module pct_counter #(
   parameter int CW       = 48,
   parameter int NUM_COND = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                clr,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic                wr_cfg,
   input  logic [31:0]         wdata,
   input  logic [NUM_COND-2:0] cond,
   output logic [CW-1:0]       cnt,
   output logic [7:0]          cfg
);
   localparam int HW = CW - 32;

   logic [CW-1:0] cnt_q;
   logic [7:0]    cfg_q;
   logic          hit;
   logic [CW-1:0] lo_merge;
   logic [CW-1:0] hi_merge;

   always_comb begin
      hit = 1'b0;
      for (int k = 1; k < NUM_COND; k++)
         if (cfg_q == 8'(k)) hit = cond[k-1];
   end

   generate
      if (HW > 0) begin : g_wide
         assign lo_merge = {cnt_q[CW-1:32], wdata};
         assign hi_merge = {wdata[HW-1:0], cnt_q[31:0]};
      end else begin : g_narrow
         assign lo_merge = wdata;
         assign hi_merge = cnt_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cfg_q <= '0;
      end else begin
         if (wr_cfg) cfg_q <= wdata[7:0];
         if (clr)             cnt_q <= '0;
         else if (wr_lo)      cnt_q <= lo_merge;
         else if (wr_hi)      cnt_q <= hi_merge;
         else if (en && hit)  cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt = cnt_q;
   assign cfg = cfg_q;

   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)); // R5
   AST_NEVER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q == 8'd0 && !clr && !wr_lo && !wr_hi) |=> $stable(cnt_q)); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr && !wr_lo && !wr_hi) |=> $stable(cnt_q)); // R4
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !wr_lo && !wr_hi) |=>
      (cnt_q == $past(cnt_q) || cnt_q == CW'($past(cnt_q) + 1'b1))); // R2
endmodule

// File: rtl/pct_bank.sv
module pct_bank import pct_pkg::*; #(
   parameter int          NUM_CNT   = 4,
   parameter int          NUM_COND  = 8,
   parameter int          SIZE_CODE = 1,
   parameter logic [7:0]  CNT_VER   = 8'h01,
   parameter logic [7:0]  COND_VER  = 8'h01
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [11:0]         bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_COND-2:0] cond_in
);
   localparam int          CW    = 32 + 16 * SIZE_CODE;
   localparam int          HW    = CW - 32;
   localparam logic [6:0]  NCNT7 = 7'(NUM_CNT);
   localparam logic [31:0] BUILD_CNT_VAL  = {8'h00, 8'(NUM_CNT), 6'b0, 2'(SIZE_CODE), CNT_VER};
   localparam logic [31:0] BUILD_COND_VAL = {16'(NUM_COND), 8'h00, COND_VER};

   generate
      if (NUM_CNT < 1 || NUM_CNT > 64) begin : g_bad_cnt
         $error("NUM_CNT must lie in 1..64");
      end
      if (NUM_COND < 2 || NUM_COND > 256) begin : g_bad_cond
         $error("NUM_COND must lie in 2..256");
      end
      if (SIZE_CODE < 0 || SIZE_CODE > 2) begin : g_bad_size
         $error("SIZE_CODE must lie in 0..2");
      end
   endgenerate

   logic [5:0]    idx_q;
   logic [7:0]    cidx_q;
   logic          en_q;
   logic [CW-1:0] snap_q;
   logic          idx_ok;

   logic wr_idx, wr_cidx, wr_cfg, wr_ctrl, wr_lo, wr_hi;
   logic clr_cmd, snap_cmd;

   assign idx_ok   = ({1'b0, idx_q} < NCNT7);
   assign wr_idx   = bus_wr && (bus_addr == A_IDX);
   assign wr_cidx  = bus_wr && (bus_addr == A_CIDX);
   assign wr_cfg   = bus_wr && (bus_addr == A_CFG);
   assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
   assign wr_lo    = bus_wr && (bus_addr == A_CNT_LO);
   assign wr_hi    = bus_wr && (bus_addr == A_CNT_HI);
   assign clr_cmd  = wr_ctrl && bus_wdata[CLR_BIT];
   assign snap_cmd = wr_ctrl && bus_wdata[SNAP_BIT];

   logic [CW-1:0] cnt_arr [NUM_CNT];
   logic [7:0]    cfg_arr [NUM_CNT];

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
         logic hit_me;
         assign hit_me = idx_ok && (idx_q == 6'(i));
         pct_counter #(.CW(CW), .NUM_COND(NUM_COND)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_q),
            .clr    (clr_cmd),
            .wr_lo  (wr_lo && hit_me),
            .wr_hi  (wr_hi && hit_me),
            .wr_cfg (wr_cfg && hit_me),
            .wdata  (bus_wdata),
            .cond   (cond_in),
            .cnt    (cnt_arr[i]),
            .cfg    (cfg_arr[i])
         );
      end
   endgenerate

   logic [CW-1:0] sel_cnt;
   logic [7:0]    sel_cfg;

   always_comb begin
      sel_cnt = '0;
      sel_cfg = '0;
      for (int i = 0; i < NUM_CNT; i++)
         if (idx_q == 6'(i)) begin
            sel_cnt = cnt_arr[i];
            sel_cfg = cfg_arr[i];
         end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         cidx_q <= '0;
         en_q   <= 1'b0;
         snap_q <= '0;
      end else begin
         if (wr_idx)  idx_q  <= bus_wdata[5:0];
         if (wr_cidx) cidx_q <= bus_wdata[7:0];
         if (wr_ctrl) en_q   <= bus_wdata[EN_BIT];
         if (snap_cmd) snap_q <= idx_ok ? sel_cnt : '0;
      end
   end

   logic [31:0] name_lo, name_hi;

   pct_names #(.NUM_COND(NUM_COND)) u_names (
      .cidx    (cidx_q),
      .word_lo (name_lo),
      .word_hi (name_hi)
   );

   logic [31:0] cnt_hi_rd, snap_hi_rd;

   generate
      if (HW > 0) begin : g_hi_rd
         assign cnt_hi_rd  = 32'(sel_cnt[CW-1:32]);
         assign snap_hi_rd = 32'(snap_q[CW-1:32]);
      end else begin : g_no_hi_rd
         assign cnt_hi_rd  = '0;
         assign snap_hi_rd = '0;
      end
   endgenerate

   always_comb begin
      case (bus_addr)
         A_IDX:      bus_rdata = {26'b0, idx_q};
         A_CFG:      bus_rdata = idx_ok ? {24'b0, sel_cfg} : '0;
         A_CTRL:     bus_rdata = {31'b0, en_q};
         A_CNT_LO:   bus_rdata = idx_ok ? sel_cnt[31:0] : '0;
         A_CNT_HI:   bus_rdata = idx_ok ? cnt_hi_rd : '0;
         A_SNP_LO:   bus_rdata = snap_q[31:0];
         A_SNP_HI:   bus_rdata = snap_hi_rd;
         A_BLD_CNT:  bus_rdata = BUILD_CNT_VAL;
         A_BLD_COND: bus_rdata = BUILD_COND_VAL;
         A_CIDX:     bus_rdata = {24'b0, cidx_q};
         A_NAME0:    bus_rdata = name_lo;
         A_NAME1:    bus_rdata = name_hi;
         default:    bus_rdata = '0;
      endcase
   end

   AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_cmd && idx_ok) |=> (snap_q == $past(sel_cnt))); // R7
   AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_cmd |=> $stable(snap_q)); // R7
   AST_CMD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_CTRL) |-> (bus_rdata[SNAP_BIT:CLR_BIT] == 2'b00)); // R5
   AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!idx_ok && bus_addr == A_CNT_LO) |-> (bus_rdata == 32'd0)); // R8
endmodule

// File: tb/pct_bank_test.sv
module pct_bank_test;
   import pct_pkg::*;

   localparam int NC    = 4;
   localparam int NCOND = 8;
   localparam int SC    = 1;
   localparam int W     = 32 + 16 * SC;
   localparam longint unsigned MASK = (64'd1 << W) - 64'd1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [11:0]       bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NCOND-2:0]  cond_in = '0;

   always #10 clk = ~clk;

   pct_bank #(.NUM_CNT(NC), .NUM_COND(NCOND), .SIZE_CODE(SC)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cond_in(cond_in)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   longint unsigned m_cnt [NC];
   int              m_cfg [NC];
   bit              m_en   = 0;
   int              m_idx  = 0;
   int              m_cidx = 0;
   longint unsigned m_snap = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_name(input int c);
      string s;
      logic [63:0] r = '0;
      if (c >= NCOND) return '0;
      s = (c == 0) ? "never" : $sformatf("cnd%02X", c);
      for (int k = 0; k < s.len(); k++) r[k*8 +: 8] = s[k];
      return r;
   endfunction

   function automatic logic [31:0] m_read(input logic [11:0] a);
      bit ok = (m_idx < NC);
      case (a)
         A_IDX:      return 32'(m_idx);
         A_CFG:      return ok ? 32'(m_cfg[m_idx]) : 32'd0;
         A_CTRL:     return {31'b0, m_en};
         A_CNT_LO:   return ok ? m_cnt[m_idx][31:0] : 32'd0;
         A_CNT_HI:   return ok ? m_cnt[m_idx][63:32] : 32'd0;
         A_SNP_LO:   return m_snap[31:0];
         A_SNP_HI:   return m_snap[63:32];
         A_BLD_CNT:  return 32'h00040101;
         A_BLD_COND: return 32'h00080001;
         A_CIDX:     return 32'(m_cidx);
         A_NAME0:    return exp_name(m_cidx)[31:0];
         A_NAME1:    return exp_name(m_cidx)[63:32];
         default:    return 32'd0;
      endcase
   endfunction

   task automatic model_edge();
      longint unsigned nxt [NC];
      bit ok = (m_idx < NC);
      for (int i = 0; i < NC; i++) begin
         nxt[i] = m_cnt[i];
         if (m_en && m_cfg[i] >= 1 && m_cfg[i] < NCOND && cond_in[m_cfg[i]-1])
            nxt[i] = (m_cnt[i] + 1) & MASK;
      end
      if (bus_wr) begin
         case (bus_addr)
            A_IDX:  m_idx  = int'(bus_wdata[5:0]);
            A_CIDX: m_cidx = int'(bus_wdata[7:0]);
            A_CFG:  if (ok) m_cfg[m_idx] = int'(bus_wdata[7:0]);
            A_CTRL: begin
               if (bus_wdata[17]) m_snap = ok ? m_cnt[m_idx] : 0;
               m_en = bus_wdata[0];
               if (bus_wdata[16]) for (int i = 0; i < NC; i++) nxt[i] = 0;
            end
            A_CNT_LO: if (ok) nxt[m_idx] = (m_cnt[m_idx] & ~64'hFFFF_FFFF) | 64'(bus_wdata);
            A_CNT_HI: if (ok) nxt[m_idx] = (64'(bus_wdata[15:0]) << 32) | (m_cnt[m_idx] & 64'hFFFF_FFFF);
            default: ;
         endcase
      end
      for (int i = 0; i < NC; i++) m_cnt[i] = nxt[i];
   endtask

   // One clock: model follows the edge, then the addressed register is compared.
   task automatic tick();
      model_edge();
      @(posedge clk);
      #2;
      chk("R2 per-cycle model", bus_rdata, m_read(bus_addr));
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input string req, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_cfg[i] = 0; end
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL,   "R1 enable", 32'd0);
      rd(A_IDX,    "R1 index", 32'd0);
      rd(A_CNT_LO, "R1 count", 32'd0);
      rd(A_CFG,    "R1 config", 32'd0);
      rd(A_SNP_LO, "R1 snapshot", 32'd0);
      rd(A_CIDX,   "R1 cond index", 32'd0);
      rd(12'h100,  "R1 unmapped", 32'd0);
      // R9 build registers
      rd(A_BLD_CNT,  "R9 counter build", 32'h00040101);
      rd(A_BLD_COND, "R9 condition build", 32'h00080001);

      // R3 selections, including out-of-range condition on counter 3
      wr(A_CFG, 32'd1);
      wr(A_IDX, 32'd1); wr(A_CFG, 32'd2);
      wr(A_IDX, 32'd2); wr(A_CFG, 32'd0);
      wr(A_IDX, 32'd3); wr(A_CFG, 32'd9);
      rd(A_CFG, "R3 config readback", 32'd9);
      wr(A_CTRL, 32'd1);
      rd(A_CTRL, "R4 enable readback", 32'd1);

      // R2 varied condition patterns, watching each counter in turn
      for (int k = 0; k < NC; k++) begin
         wr(A_IDX, 32'(k));
         bus_addr = A_CNT_LO;
         for (int c = 0; c < 12; c++) begin
            cond_in = 7'((c * 37 + k * 11) ^ (c >> 1));
            tick();
         end
      end
      cond_in = '1;
      repeat (5) tick();
      rd(A_CNT_LO, "R3 out-of-range condition never counts", 32'd0);
      wr(A_IDX, 32'd2);
      rd(A_CNT_LO, "R3 condition zero never counts", 32'd0);

      // R4 disable holds
      wr(A_CTRL, 32'd0);
      wr(A_IDX, 32'd0);
      v = m_read(A_CNT_LO);
      repeat (5) tick();
      rd(A_CNT_LO, "R4 disabled counter holds", v);

      // R2 wrap at 48 bits, R6 preset of both halves
      wr(A_CNT_HI, 32'h0000FFFF);
      wr(A_CNT_LO, 32'hFFFFFFFE);
      rd(A_CNT_HI, "R6 high preset", 32'h0000FFFF);
      rd(A_CNT_LO, "R6 low preset keeps high", 32'hFFFFFFFE);
      wr(A_CTRL, 32'd1);
      tick(); tick();
      rd(A_CNT_LO, "R2 wrap low", 32'd0);
      rd(A_CNT_HI, "R2 wrap high", 32'd0);

      // R6 write wins over a same-edge increment
      wr(A_CNT_LO, 32'h00001234);
      rd(A_CNT_LO, "R6 write priority", 32'h00001234);
      tick();
      rd(A_CNT_LO, "R2 count after preset", 32'h00001235);

      // R7 snapshot takes the value before the edge
      v = 32'h00001235;
      wr(A_CTRL, 32'h0002_0001);
      rd(A_SNP_LO, "R7 snapshot low", v);
      rd(A_SNP_HI, "R7 snapshot high", 32'd0);
      rd(A_CTRL,   "R5 command bits read zero", 32'd1);
      repeat (4) tick();
      rd(A_SNP_LO, "R7 snapshot stable", v);
      rd(A_CNT_LO, "R7 counter runs on", v + 32'd5);

      // R5 clear beats increment on all counters
      wr(A_CTRL, 32'h0001_0001);
      rd(A_CNT_LO, "R5 clear with enable", 32'd0);
      wr(A_CTRL, 32'h0001_0000);
      for (int k = 0; k < NC; k++) begin
         wr(A_IDX, 32'(k));
         rd(A_CNT_LO, "R5 all counters cleared", 32'd0);
      end

      // R8 index beyond the bank
      wr(A_IDX, 32'd5);
      rd(A_IDX,    "R8 index readback", 32'd5);
      rd(A_CNT_LO, "R8 out-of-range count", 32'd0);
      rd(A_CFG,    "R8 out-of-range config", 32'd0);
      wr(A_CNT_LO, 32'h0000ABCD);
      wr(A_CFG, 32'd3);
      wr(A_CTRL, 32'h0002_0000);
      rd(A_SNP_LO, "R8 out-of-range snapshot", 32'd0);
      for (int k = 0; k < NC; k++) begin
         wr(A_IDX, 32'(k));
         rd(A_CNT_LO, "R8 writes ignored count", 32'd0);
         rd(A_CFG, "R8 writes ignored config", m_read(A_CFG));
      end

      // R10 condition names
      wr(A_CIDX, 32'd0);
      rd(A_NAME0, "R10 name zero low", 32'h6576656E);
      rd(A_NAME1, "R10 name zero high", 32'h00000072);
      wr(A_CIDX, 32'd5);
      rd(A_NAME0, "R10 name five low", 32'h30646E63);
      rd(A_NAME1, "R10 name five high", 32'h00000035);
      wr(A_CIDX, 32'd7);
      rd(A_NAME1, "R10 name seven high", exp_name(7)[63:32]);
      wr(A_CIDX, 32'd8);
      rd(A_NAME0, "R10 name out of range", 32'd0);
      rd(12'h7FF, "R1 unmapped late", 32'd0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule